// File: doc/BRIEF.md
# Timestamping Serial Traffic Listener

This block watches both directions of a serial link to a device under test without taking part in it. A UART receiver in front of it presents each byte with a one-cycle strobe: one port carries bytes arriving from the device, the other carries bytes being sent toward it. While listening is switched on, every such byte is tagged with the value of a free-running 16-bit cycle counter. The tagged byte is then stored as a record in a FIFO that belongs to its direction.

A merge stage drains the two FIFOs into one stream of 16-bit words with a valid/ready handshake, heading back toward the host. Each record becomes two adjacent words: the timestamp first, then a data word that holds the byte, a direction flag and an overflow marker. When both FIFOs hold records, the older timestamp goes first, so the host can rebuild the timing of the traffic across both directions. A host command turns listening on or off. Turning it off only stops new captures; records already queued still come out.

Top module: `serial_listen_tap`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid` is low, and listening is off after reset.
- R2: A strobe is captured only while listening is on. A cycle with `cmd_valid` high sets listening to `cmd_listen` (1 = on, 0 = off) from the next cycle on, so a strobe in the same cycle as the command is judged by the old setting.
- R3: The first word of each record is the stamp: the value of a 16-bit counter in the cycle the strobe was high. The counter reads 0 in the first cycle after reset is released, then increases by 1 each cycle and wraps.
- R4: The second word of a record holds the byte in bits [7:0] and the direction in bit 8 (0 = byte from the device, `dev_rx_*`; 1 = byte toward the device, `dev_tx_*`). Bits [14:9] are zero and bit 15 is the overflow marker.
- R5: Each direction has its own FIFO of `DEPTH` records, and records of one direction leave in capture order.
- R6: Between directions, the record with the older stamp leaves first, and on equal stamps the direction-0 record leaves first. The two words of a record are always transferred back to back.
- R7: A byte that is captured while its direction's FIFO is full is dropped. The next record that FIFO accepts carries bit 15 = 1, and later records carry 0 again.
- R8: Turning listening off discards nothing: records queued before the command are still delivered in full, and nothing more is added.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe for the listen setting |
| cmd_listen | input | 1 | New listen setting, 1 = on |
| dev_rx_valid | input | 1 | Byte received from the device is present this cycle |
| dev_rx_byte | input | 8 | Byte received from the device |
| dev_tx_valid | input | 1 | Byte sent toward the device is present this cycle |
| dev_tx_byte | input | 8 | Byte sent toward the device |
| out_ready | input | 1 | Host path accepts `out_word` this cycle |
| out_valid | output | 1 | `out_word` holds a word |
| out_word | output | 16 | Stamp word or data word of a record |

## Verification
A corrupted FIFO pointer shows up at the ports as a record that is repeated, lost or out of sequence, in the first record drained after the fault. A stuck sticky-drop flag marks bit 15 on the wrong record, or on none. A wrong merge choice puts a newer stamp ahead of an older one on the very next record pair. A lost phase bit splits a record, so a stamp word follows another stamp word within one transfer. The directed tests drain known records and compare every word, stamp and flag against values the bench derives from its own cycle count.

// File: rtl/lsn_pkg.sv
package lsn_pkg;
  localparam int unsigned STAMP_W = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned LANES   = 2;

  typedef struct packed {
    logic                ovf;
    logic [BYTE_W-1:0]   data;
    logic [STAMP_W-1:0]  stamp;
  } rec_t;
endpackage

// File: rtl/lsn_stamp_ctr.sv
module lsn_stamp_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + 1'b1;
  end
endmodule

// File: rtl/lsn_lane.sv
module lsn_lane #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic                        strobe,
  input  logic [lsn_pkg::BYTE_W-1:0]  byte_in,
  input  logic [lsn_pkg::STAMP_W-1:0] stamp,
  input  logic                        pop,
  output logic                        empty,
  output lsn_pkg::rec_t               head
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  lsn_pkg::rec_t mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          lost_q;
  logic          full, push, drop;

  assign full  = (wr_ptr - rd_ptr) == (AW+1)'(DEPTH);
  assign empty = (wr_ptr == rd_ptr);
  assign push  = en && strobe && !full;
  assign drop  = en && strobe && full;
  assign head  = mem[rd_ptr[AW-1:0]];

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= '{ovf: lost_q, data: byte_in, stamp: stamp};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      lost_q <= 1'b0;
    end else begin
      if (push) begin
        wr_ptr <= wr_ptr + 1'b1;
        lost_q <= 1'b0;
      end else if (drop) begin
        lost_q <= 1'b1;
      end
      if (pop) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/lsn_merge.sv
module lsn_merge (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [1:0]                  empty,
  input  lsn_pkg::rec_t               head [2],
  input  logic                        out_ready,
  output logic [1:0]                  pop,
  output logic                        out_valid,
  output logic [lsn_pkg::WORD_W-1:0]  out_word,
  output logic                        out_is_data
);
  localparam int unsigned SW = lsn_pkg::STAMP_W;

  logic          phase_q, sel_q;
  logic          can_load, any, pick;
  logic [SW-1:0] diff;
  lsn_pkg::rec_t cur;

  assign can_load = !out_valid || out_ready;
  assign any      = !(&empty);
  assign diff     = head[0].stamp - head[1].stamp;
  // wrap-aware age compare; ties favour direction 0
  assign pick     = empty[0] ? 1'b1 :
                    empty[1] ? 1'b0 : (!diff[SW-1] && (diff != '0));
  assign cur      = head[sel_q];
  assign pop      = (phase_q && can_load) ? (sel_q ? 2'b10 : 2'b01) : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q     <= 1'b0;
      sel_q       <= 1'b0;
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_is_data <= 1'b0;
    end else if (can_load) begin
      if (phase_q) begin
        out_valid   <= 1'b1;
        out_word    <= {cur.ovf, 6'b0, sel_q, cur.data};
        out_is_data <= 1'b1;
        phase_q     <= 1'b0;
      end else if (any) begin
        out_valid   <= 1'b1;
        out_word    <= head[pick].stamp;
        out_is_data <= 1'b0;
        sel_q       <= pick;
        phase_q     <= 1'b1;
      end else begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_listen_tap.sv
module serial_listen_tap #(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic        cmd_listen,
  input  logic        dev_rx_valid,
  input  logic [7:0]  dev_rx_byte,
  input  logic        dev_tx_valid,
  input  logic [7:0]  dev_tx_byte,
  input  logic        out_ready,
  output logic        out_valid,
  output logic [15:0] out_word
);
  localparam int unsigned LANES = lsn_pkg::LANES;

  logic                        listen_q;
  logic [lsn_pkg::STAMP_W-1:0] stamp_now;
  logic [LANES-1:0]            lane_strobe, lane_empty, lane_pop;
  logic [7:0]                  lane_byte [LANES];
  lsn_pkg::rec_t               lane_head [LANES];
  logic                        word_is_data;

  assign lane_strobe  = {dev_tx_valid, dev_rx_valid};
  assign lane_byte[0] = dev_rx_byte;
  assign lane_byte[1] = dev_tx_byte;

  always_ff @(posedge clk) begin
    if (rst)            listen_q <= 1'b0;
    else if (cmd_valid) listen_q <= cmd_listen;
  end

  lsn_stamp_ctr #(.W(lsn_pkg::STAMP_W)) stamp_i (
    .clk(clk), .rst(rst), .count(stamp_now)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lsn_lane #(.DEPTH(DEPTH)) lane_i (
      .clk(clk), .rst(rst), .en(listen_q),
      .strobe(lane_strobe[g]), .byte_in(lane_byte[g]), .stamp(stamp_now),
      .pop(lane_pop[g]), .empty(lane_empty[g]), .head(lane_head[g])
    );
  end

  lsn_merge merge_i (
    .clk(clk), .rst(rst), .empty(lane_empty), .head(lane_head),
    .out_ready(out_ready), .pop(lane_pop), .out_valid(out_valid),
    .out_word(out_word), .out_is_data(word_is_data)
  );
endmodule

// File: rtl/serial_listen_tap_chk.sv
module serial_listen_tap_chk (
  input logic        clk,
  input logic        rst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_word,
  input logic        out_is_data,
  input logic [1:0]  lane_pop,
  input logic [1:0]  lane_empty
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_pop) && ((lane_pop & lane_empty) == 2'b00));

  // R6
  pair_adjacent_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && !out_is_data |=> out_valid && out_is_data);

  // R4
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_is_data |-> out_word[14:9] == 6'b0);
endmodule

bind serial_listen_tap serial_listen_tap_chk chk_i (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_is_data(word_is_data),
  .lane_pop(lane_pop), .lane_empty(lane_empty)
);

// File: tb/serial_listen_tap_tb_top.sv
module serial_listen_tap_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_listen = 1'b0;
  logic        dev_rx_valid = 1'b0, dev_tx_valid = 1'b0;
  logic [7:0]  dev_rx_byte = '0, dev_tx_byte = '0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_word;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [15:0] tb_cnt;
  logic [15:0] got [64];
  logic [15:0] sts [32];
  int ngot;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) tb_cnt <= '0;
    else     tb_cnt <= tb_cnt + 16'd1;
  end

  serial_listen_tap #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_listen(cmd_listen),
    .dev_rx_valid(dev_rx_valid), .dev_rx_byte(dev_rx_byte),
    .dev_tx_valid(dev_tx_valid), .dev_tx_byte(dev_tx_byte),
    .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [15:0] dword(input logic ovf, input logic dir, input logic [7:0] b);
    return {ovf, 6'b0, dir, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic dir, input logic [7:0] b, output logic [15:0] st);
    @(negedge clk);
    if (dir) begin dev_tx_valid = 1'b1; dev_tx_byte = b; end
    else     begin dev_rx_valid = 1'b1; dev_rx_byte = b; end
    st = tb_cnt;
    @(negedge clk);
    dev_rx_valid = 1'b0;
    dev_tx_valid = 1'b0;
  endtask

  task automatic command(input logic on);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_listen = on;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic collect(input int n, input string tag);
    int guard = 0;
    ngot = 0;
    @(negedge clk);
    out_ready = 1'b1;
    while (ngot < n && guard < 1000) begin
      if (out_valid) begin got[ngot] = out_word; ngot++; end
      guard++;
      if (ngot < n) @(negedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(ngot == n, {tag, " word count"}, 16'(ngot), 16'(n));
  endtask

  task automatic quiet(input int n, input string tag);
    int seen = 0;
    @(negedge clk);
    out_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (out_valid) seen++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(seen == 0, {tag, " no output"}, 16'(seen), 16'd0);
  endtask

  task automatic chk_rec(input int idx, input logic [15:0] st, input logic dir,
                         input logic [7:0] b, input logic ovf, input string tag);
    chk(got[2*idx] == st, {tag, " stamp"}, got[2*idx], st);
    chk(got[2*idx+1] == dword(ovf, dir, b), {tag, " data"}, got[2*idx+1], dword(ovf, dir, b));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 16'(out_valid), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", 16'(out_valid), 16'd0);
  endtask

  task automatic t_off_ignored();
    logic [15:0] s;
    send(1'b0, 8'h11, s);
    send(1'b1, 8'h22, s);
    quiet(10, "R2 listening off");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_listen = 1'b1;
    dev_rx_valid = 1'b1; dev_rx_byte = 8'hAA;
    @(negedge clk);
    cmd_valid = 1'b0; dev_rx_byte = 8'hBB; s = tb_cnt;
    @(negedge clk);
    dev_rx_valid = 1'b0;
    collect(2, "R2 first capture");
    chk_rec(0, s, 1'b0, 8'hBB, 1'b0, "R2 same-cycle strobe skipped");
    quiet(10, "R2 no late record");
  endtask

  task automatic t_format();
    logic [15:0] s;
    send(1'b1, 8'h5A, s);
    collect(2, "R4 toward device");
    chk_rec(0, s, 1'b1, 8'h5A, 1'b0, "R3 R4 dir1 record");
    send(1'b0, 8'hC3, s);
    collect(2, "R4 from device");
    chk_rec(0, s, 1'b0, 8'hC3, 1'b0, "R3 R4 dir0 record");
  endtask

  task automatic t_order();
    logic [15:0] a, b, c;
    send(1'b0, 8'h01, a);
    send(1'b1, 8'h02, b);
    send(1'b0, 8'h03, c);
    collect(6, "R6 age order");
    chk_rec(0, a, 1'b0, 8'h01, 1'b0, "R6 first");
    chk_rec(1, b, 1'b1, 8'h02, 1'b0, "R6 older dir1 before newer dir0");
    chk_rec(2, c, 1'b0, 8'h03, 1'b0, "R6 last");
    send(1'b0, 8'h10, a);
    send(1'b0, 8'h11, b);
    send(1'b0, 8'h12, c);
    collect(6, "R5 lane order");
    chk_rec(0, a, 1'b0, 8'h10, 1'b0, "R5 rec0");
    chk_rec(1, b, 1'b0, 8'h11, 1'b0, "R5 rec1");
    chk_rec(2, c, 1'b0, 8'h12, 1'b0, "R5 rec2");
    @(negedge clk);
    dev_rx_valid = 1'b1; dev_rx_byte = 8'h40;
    dev_tx_valid = 1'b1; dev_tx_byte = 8'h41;
    a = tb_cnt;
    @(negedge clk);
    dev_rx_valid = 1'b0; dev_tx_valid = 1'b0;
    collect(4, "R6 tie");
    chk_rec(0, a, 1'b0, 8'h40, 1'b0, "R6 tie dir0 first");
    chk_rec(1, a, 1'b1, 8'h41, 1'b0, "R6 tie dir1 second");
  endtask

  task automatic t_overflow();
    logic [15:0] s;
    for (int i = 0; i < DEPTH; i++) send(1'b0, 8'(i), sts[i]);
    send(1'b0, 8'hE0, s);
    send(1'b0, 8'hE1, s);
    collect(2, "R7 head");
    chk_rec(0, sts[0], 1'b0, 8'h00, 1'b0, "R7 first kept");
    send(1'b0, 8'h77, sts[DEPTH]);
    collect(2*DEPTH, "R7 drain");
    for (int i = 1; i < DEPTH; i++)
      chk_rec(i-1, sts[i], 1'b0, 8'(i), 1'b0, "R7 kept record");
    chk_rec(DEPTH-1, sts[DEPTH], 1'b0, 8'h77, 1'b1, "R7 marker after drop");
    send(1'b0, 8'h78, s);
    collect(2, "R7 clear");
    chk_rec(0, s, 1'b0, 8'h78, 1'b0, "R7 marker cleared");
  endtask

  task automatic t_backpressure();
    logic [15:0] s, w0;
    send(1'b1, 8'h66, s);
    @(negedge clk);
    w0 = out_word;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid && out_word == w0, "R9 held under stall", out_word, w0);
    end
    collect(2, "R9 release");
    chk_rec(0, s, 1'b1, 8'h66, 1'b0, "R9 record intact");
  endtask

  task automatic t_disable();
    logic [15:0] a, b, c, s;
    send(1'b0, 8'h31, a);
    send(1'b1, 8'h32, b);
    send(1'b0, 8'h33, c);
    command(1'b0);
    send(1'b0, 8'h34, s);
    send(1'b1, 8'h35, s);
    collect(6, "R8 drain after off");
    chk_rec(0, a, 1'b0, 8'h31, 1'b0, "R8 rec0");
    chk_rec(1, b, 1'b1, 8'h32, 1'b0, "R8 rec1");
    chk_rec(2, c, 1'b0, 8'h33, 1'b0, "R8 rec2");
    quiet(20, "R8 nothing added");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_off_ignored();
    t_format();
    t_order();
    t_overflow();
    t_backpressure();
    t_disable();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule